// File: doc/BRIEF.md
# Shared Code RAM with Stop Control

This block is a 1024 x 16 RAM with two ways in. A host port carries 16-bit bus cycles. A 32-bit word write reaches the array as two back-to-back half-word writes, with the upper half first. A read-only engine port lets a microcode sequencer fetch instruction words while emulation is enabled. A small register space, selected by the top host address bit, holds one control register. That register has a stop bit, an array-disable bit and an emulation-enable bit.

Setting the stop bit closes the array to both ports and keeps its contents. Only the control register still answers the host. The reset is synchronous. It cuts short a word write that has finished only its first half, and it lets a word write that is on its second half finish. The freeze input is accepted and ignored.

The array is one single-ported memory with a registered read. Each cycle, one port owns it, and the engine port has priority. When the engine takes the array, a host array access is held and the wait output is raised.

Top module: `shared_code_ram`

## Requirements
- R1: After reset, the control register reads 0, and host_done and eng_rvalid are low.
- R2: A half-word host write stores host_wdata[15:0] at host_addr[9:0]. A half-word host read returns the stored value on host_rdata. In both cases host_done pulses one cycle after the request is accepted.
- R3: A word write (host_word=1) with host_addr[10]=0 stores host_wdata[31:16] at the even address {host_addr[9:1],0}, then host_wdata[15:0] at the next odd address, and pulses host_done two cycles after acceptance.
- R4: If reset is high at the clock edge that stores the upper half of a word write, that half is stored, the lower half is never written, and host_done does not pulse.
- R5: If reset is high at the clock edge that stores the lower half of a word write, both halves are stored.
- R6: While the stop bit is 1, host array reads return 0, host array writes are ignored, engine requests get no eng_rvalid, and the control register stays writable. After stop is cleared, the array holds the data it had before.
- R7: A control write that changes the stop bit updates only the stop bit, and the disable and emulation bits keep their old values. While stop is 1, those two bits cannot change.
- R8: While the disable bit is 1, host array reads return 0 and host array writes are ignored. Register accesses work, and the engine port can still read the array.
- R9: When emulation is 1 and stop is 0, an engine request raises eng_rvalid one cycle later, with the word at eng_addr on eng_rdata. When emulation is 0, eng_rvalid stays low.
- R10: When the engine and the host want the array in the same cycle, the engine is served, host_wait is high in that cycle, and the host access completes later.
- R11: The freeze input has no effect on reads, writes or engine fetches.
- R12: host_addr[10]=1 selects register space. Offset 0 is the control register, with bit 0 = stop, bit 1 = disable and bit 2 = emulation, and its other bits read 0. Other offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | Debug freeze, ignored |
| host_valid | input | 1 | Host request, held until host_done |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_word | input | 1 | 1 = 32-bit write split into two half-word cycles |
| host_addr | input | 11 | Bit 10 selects register space, bits 9:0 select the half-word |
| host_wdata | input | 32 | Write data (bits 15:0 for half-word and register writes) |
| host_done | output | 1 | One-cycle completion pulse |
| host_wait | output | 1 | Host array access held off by the engine this cycle |
| host_rdata | output | 16 | Read data, valid with host_done |
| eng_req | input | 1 | Engine fetch request |
| eng_addr | input | 10 | Engine fetch address |
| eng_rvalid | output | 1 | Engine data valid |
| eng_rdata | output | 16 | Engine fetch data |

## Verification
The assertions assume a well-behaved host. It keeps host_valid and its fields steady until host_done, and it does not start a new request in the cycle after host_done. It drops any pending request while reset is high, because a request still present after reset would be taken as new. The bench tasks follow these rules. Each task holds a request until it sees host_done, and the reset tests clear the host request in the same cycle that reset falls. The bench changes the control register only between host transactions, so the stop and disable bits never change while a word write is in progress.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int CTRL_STOP_BIT = 0;
  localparam int CTRL_OFF_BIT  = 1;
  localparam int CTRL_EMU_BIT  = 2;

  typedef struct packed {
    logic emu;
    logic off;
    logic stop;
  } ctrl_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_LOW  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/scr_sp_ram.sv
module scr_sp_ram #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Single port, read-first, registered output: block RAM shape.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/scr_ctrl_reg.sv
module scr_ctrl_reg
  import scr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output ctrl_t         ctrl,
  output logic [DW-1:0] rdata
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en) begin
      if (wdata[CTRL_STOP_BIT] != ctrl.stop) begin
        // A stop transition masks every other field.
        ctrl.stop <= wdata[CTRL_STOP_BIT];
      end else if (!ctrl.stop) begin
        ctrl.off <= wdata[CTRL_OFF_BIT];
        ctrl.emu <= wdata[CTRL_EMU_BIT];
      end
    end
  end

  always_comb begin
    rdata                = '0;
    rdata[CTRL_STOP_BIT] = ctrl.stop;
    rdata[CTRL_OFF_BIT]  = ctrl.off;
    rdata[CTRL_EMU_BIT]  = ctrl.emu;
  end
endmodule

// File: rtl/scr_host_seq.sv
module scr_host_seq
  import scr_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_valid,
  input  logic            host_wr,
  input  logic            host_word,
  input  logic [AW:0]     host_addr,
  input  logic [2*DW-1:0] host_wdata,
  input  logic            eng_busy,
  input  ctrl_t           ctrl,
  input  logic [DW-1:0]   reg_rdata,
  output logic            ram_en,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            reg_wr,
  output logic            host_wait,
  output logic            host_done,
  output logic            rd_from_ram,
  output logic [DW-1:0]   rdata_q
);
  seq_state_e    state_q, state_d;
  logic          finish;
  logic          from_ram_d;
  logic [DW-1:0] rdata_d;
  logic          is_reg;
  logic [AW-1:0] offs;
  logic          arr_open;
  logic          accept;

  assign is_reg   = host_addr[AW];
  assign offs     = host_addr[AW-1:0];
  assign arr_open = !ctrl.stop && !ctrl.off;
  assign accept   = (state_q == SEQ_IDLE) && host_valid && !host_done;

  always_comb begin
    state_d    = state_q;
    finish     = 1'b0;
    from_ram_d = 1'b0;
    rdata_d    = '0;
    ram_en     = 1'b0;
    ram_we     = 1'b0;
    ram_addr   = offs;
    ram_wdata  = host_wdata[DW-1:0];
    reg_wr     = 1'b0;
    host_wait  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (accept) begin
          if (is_reg) begin
            reg_wr  = host_wr && (offs == '0);
            rdata_d = (offs == '0) ? reg_rdata : '0;
            finish  = 1'b1;
          end else if (!arr_open) begin
            finish = 1'b1;
          end else if (eng_busy) begin
            host_wait = 1'b1;
          end else begin
            ram_en = 1'b1;
            ram_we = host_wr;
            if (host_wr && host_word) begin
              ram_addr  = {offs[AW-1:1], 1'b0};
              ram_wdata = host_wdata[2*DW-1:DW];
              state_d   = SEQ_LOW;
            end else begin
              from_ram_d = !host_wr;
              finish     = 1'b1;
            end
          end
        end
      end
      SEQ_LOW: begin
        if (eng_busy) begin
          host_wait = 1'b1;
        end else begin
          ram_en    = 1'b1;
          ram_we    = 1'b1;
          ram_addr  = {offs[AW-1:1], 1'b1};
          ram_wdata = host_wdata[DW-1:0];
          finish    = 1'b1;
          state_d   = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SEQ_IDLE;
      host_done   <= 1'b0;
      rd_from_ram <= 1'b0;
      rdata_q     <= '0;
    end else begin
      state_q     <= state_d;
      host_done   <= finish;
      rd_from_ram <= finish && from_ram_d;
      if (finish) rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/shared_code_ram.sv
module shared_code_ram
  import scr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                freeze,
  input  logic                host_valid,
  input  logic                host_wr,
  input  logic                host_word,
  input  logic [ADDR_W:0]     host_addr,
  input  logic [2*DATA_W-1:0] host_wdata,
  output logic                host_done,
  output logic                host_wait,
  output logic [DATA_W-1:0]   host_rdata,
  input  logic                eng_req,
  input  logic [ADDR_W-1:0]   eng_addr,
  output logic                eng_rvalid,
  output logic [DATA_W-1:0]   eng_rdata
);
  ctrl_t               ctrl;
  logic [DATA_W-1:0]   reg_rdata;
  logic                reg_wr;
  logic                eng_grant;
  logic                h_en, h_we;
  logic [ADDR_W-1:0]   h_addr;
  logic [DATA_W-1:0]   h_wdata;
  logic                ram_en, ram_we;
  logic [ADDR_W-1:0]   ram_addr;
  logic [DATA_W-1:0]   ram_q;
  logic                rd_from_ram;
  logic [DATA_W-1:0]   rdata_q;
  logic                ctrl_stop, ctrl_off, ctrl_emu;
  logic                unused_freeze;

  assign unused_freeze = freeze;
  assign ctrl_stop     = ctrl.stop;
  assign ctrl_off      = ctrl.off;
  assign ctrl_emu      = ctrl.emu;

  // Engine owns the array whenever it asks and is allowed.
  assign eng_grant = eng_req && ctrl.emu && !ctrl.stop;

  scr_ctrl_reg #(.DW(DATA_W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr_en (reg_wr),
    .wdata (host_wdata[DATA_W-1:0]),
    .ctrl  (ctrl),
    .rdata (reg_rdata)
  );

  scr_host_seq #(.DW(DATA_W), .AW(ADDR_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .host_valid  (host_valid),
    .host_wr     (host_wr),
    .host_word   (host_word),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .eng_busy    (eng_grant),
    .ctrl        (ctrl),
    .reg_rdata   (reg_rdata),
    .ram_en      (h_en),
    .ram_we      (h_we),
    .ram_addr    (h_addr),
    .ram_wdata   (h_wdata),
    .reg_wr      (reg_wr),
    .host_wait   (host_wait),
    .host_done   (host_done),
    .rd_from_ram (rd_from_ram),
    .rdata_q     (rdata_q)
  );

  assign ram_en   = eng_grant || h_en;
  assign ram_we   = !eng_grant && h_we;
  assign ram_addr = eng_grant ? eng_addr : h_addr;

  scr_sp_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (h_wdata),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) eng_rvalid <= 1'b0;
    else     eng_rvalid <= eng_grant;
  end

  assign eng_rdata  = ram_q;
  assign host_rdata = rd_from_ram ? ram_q : rdata_q;
endmodule

// File: rtl/shared_code_ram_chk.sv
module shared_code_ram_chk (
  input logic clk,
  input logic rst,
  input logic host_done,
  input logic host_wait,
  input logic eng_req,
  input logic eng_rvalid,
  input logic ctrl_stop,
  input logic ctrl_off,
  input logic ctrl_emu,
  input logic ram_we
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  assert_eng_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (eng_req && ctrl_emu && !ctrl_stop) |=> eng_rvalid);

  assert_eng_blocked_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (eng_req && ctrl_stop) |=> !eng_rvalid);

  assert_stop_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl_stop |-> !ram_we);

  assert_off_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl_off |-> !ram_we);

  assert_wait_engine_R10: assert property (@(posedge clk) disable iff (rst)
    host_wait |-> (eng_req && ctrl_emu));

  assert_wait_no_done_R10: assert property (@(posedge clk) disable iff (rst)
    host_wait |=> !host_done);
endmodule

bind shared_code_ram shared_code_ram_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_done  (host_done),
  .host_wait  (host_wait),
  .eng_req    (eng_req),
  .eng_rvalid (eng_rvalid),
  .ctrl_stop  (ctrl_stop),
  .ctrl_off   (ctrl_off),
  .ctrl_emu   (ctrl_emu),
  .ram_we     (ram_we)
);

// File: tb/shared_code_ram_tb_top.sv
module shared_code_ram_tb_top;
  localparam logic [10:0] REG_CTRL = 11'h400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        freeze = 1'b0;
  logic        host_valid = 1'b0, host_wr = 1'b0, host_word = 1'b0;
  logic [10:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_done, host_wait;
  logic [15:0] host_rdata;
  logic        eng_req = 1'b0;
  logic [9:0]  eng_addr = '0;
  logic        eng_rvalid;
  logic [15:0] eng_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  shared_code_ram dut_i (
    .clk(clk), .rst(rst), .freeze(freeze),
    .host_valid(host_valid), .host_wr(host_wr), .host_word(host_word),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_done(host_done), .host_wait(host_wait), .host_rdata(host_rdata),
    .eng_req(eng_req), .eng_addr(eng_addr),
    .eng_rvalid(eng_rvalid), .eng_rdata(eng_rdata)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<100000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic host_op(input logic wr, input logic word, input logic [10:0] a,
                         input logic [31:0] wd, output logic [15:0] rd, output int lat);
    @(negedge clk);
    host_valid = 1'b1; host_wr = wr; host_word = word; host_addr = a; host_wdata = wd;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!host_done && lat < 20);
    rd = host_rdata;
    host_valid = 1'b0; host_word = 1'b0; host_wr = 1'b0;
  endtask

  task automatic wr16(input logic [10:0] a, input logic [15:0] d);
    logic [15:0] rd; int lat;
    host_op(1'b1, 1'b0, a, {16'h0, d}, rd, lat);
  endtask

  task automatic rd16(input logic [10:0] a, output logic [15:0] d);
    int lat;
    host_op(1'b0, 1'b0, a, 32'h0, d, lat);
  endtask

  task automatic eng_read(input logic [9:0] a, output logic v, output logic [15:0] d);
    @(negedge clk);
    eng_req = 1'b1; eng_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = eng_rvalid; d = eng_rdata;
    eng_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 done low after reset", {31'b0, host_done}, 32'h0);
    chk("R1 rvalid low after reset", {31'b0, eng_rvalid}, 32'h0);
    rd16(REG_CTRL, d);
    chk("R1 ctrl reads 0", {16'h0, d}, 32'h0);
    wr16(REG_CTRL + 11'd5, 16'hFFFF);
    rd16(REG_CTRL + 11'd5, d);
    chk("R12 unused offset reads 0", {16'h0, d}, 32'h0);
  endtask

  task automatic t_half();
    logic [15:0] d; int lat;
    host_op(1'b1, 1'b0, 11'd5, 32'h0000_1234, d, lat);
    chk("R2 write latency", lat, 1);
    host_op(1'b0, 1'b0, 11'd5, 32'h0, d, lat);
    chk("R2 read latency", lat, 1);
    chk("R2 readback", {16'h0, d}, 32'h1234);
    wr16(11'd6, 16'h00FF);
    rd16(11'd6, d);
    chk("R2 second pattern", {16'h0, d}, 32'h00FF);
  endtask

  task automatic t_word();
    logic [15:0] d; int lat;
    host_op(1'b1, 1'b1, 11'd8, 32'hAABB_CCDD, d, lat);
    chk("R3 word latency", lat, 2);
    rd16(11'd8, d); chk("R3 upper half at even", {16'h0, d}, 32'hAABB);
    rd16(11'd9, d); chk("R3 lower half at odd", {16'h0, d}, 32'hCCDD);
    host_op(1'b1, 1'b1, 11'd11, 32'h1357_2468, d, lat);
    rd16(11'd10, d); chk("R3 odd addr upper", {16'h0, d}, 32'h1357);
    rd16(11'd11, d); chk("R3 odd addr lower", {16'h0, d}, 32'h2468);
  endtask

  task automatic t_reset_first();
    logic [15:0] d;
    wr16(11'd20, 16'h1111);
    wr16(11'd21, 16'h2222);
    @(negedge clk);
    host_valid = 1'b1; host_wr = 1'b1; host_word = 1'b1;
    host_addr = 11'd20; host_wdata = 32'h3333_4444;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; host_valid = 1'b0; host_word = 1'b0; host_wr = 1'b0;
    chk("R4 no done after cut word", {31'b0, host_done}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 no late done", {31'b0, host_done}, 32'h0);
    rd16(11'd20, d); chk("R4 upper new", {16'h0, d}, 32'h3333);
    rd16(11'd21, d); chk("R4 lower old", {16'h0, d}, 32'h2222);
  endtask

  task automatic t_reset_second();
    logic [15:0] d;
    wr16(11'd30, 16'h5555);
    wr16(11'd31, 16'h6666);
    @(negedge clk);
    host_valid = 1'b1; host_wr = 1'b1; host_word = 1'b1;
    host_addr = 11'd30; host_wdata = 32'h7777_8888;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; host_valid = 1'b0; host_word = 1'b0; host_wr = 1'b0;
    rd16(11'd30, d); chk("R5 upper new", {16'h0, d}, 32'h7777);
    rd16(11'd31, d); chk("R5 lower new", {16'h0, d}, 32'h8888);
  endtask

  task automatic t_ctrl();
    logic [15:0] d;
    wr16(REG_CTRL, 16'h0006);
    rd16(REG_CTRL, d); chk("R12 ctrl emu+off", {16'h0, d}, 32'h6);
    wr16(REG_CTRL, 16'h0001);
    rd16(REG_CTRL, d); chk("R7 stop set keeps others", {16'h0, d}, 32'h7);
    wr16(REG_CTRL, 16'h0005);
    rd16(REG_CTRL, d); chk("R7 others locked in stop", {16'h0, d}, 32'h7);
    wr16(REG_CTRL, 16'h0000);
    rd16(REG_CTRL, d); chk("R7 stop clear keeps others", {16'h0, d}, 32'h6);
    wr16(REG_CTRL, 16'h0000);
    rd16(REG_CTRL, d); chk("R12 ctrl cleared", {16'h0, d}, 32'h0);
  endtask

  task automatic t_stop();
    logic [15:0] d; logic v;
    wr16(11'd40, 16'hBEEF);
    wr16(REG_CTRL, 16'h0004);
    wr16(REG_CTRL, 16'h0005);
    rd16(REG_CTRL, d); chk("R6 stop set", {16'h0, d}, 32'h5);
    rd16(11'd40, d); chk("R6 stop read zero", {16'h0, d}, 32'h0);
    wr16(11'd40, 16'h0000);
    eng_read(10'd40, v, d);
    chk("R6 engine blocked", {31'b0, v}, 32'h0);
    wr16(REG_CTRL, 16'h0004);
    rd16(REG_CTRL, d); chk("R6 stop cleared via ctrl", {16'h0, d}, 32'h4);
    rd16(11'd40, d); chk("R6 contents kept", {16'h0, d}, 32'hBEEF);
    wr16(REG_CTRL, 16'h0000);
  endtask

  task automatic t_off();
    logic [15:0] d; logic v;
    wr16(11'd50, 16'h5A5A);
    wr16(REG_CTRL, 16'h0006);
    rd16(11'd50, d); chk("R8 disabled read zero", {16'h0, d}, 32'h0);
    wr16(11'd50, 16'h0000);
    rd16(REG_CTRL, d); chk("R8 regs still work", {16'h0, d}, 32'h6);
    eng_read(10'd50, v, d);
    chk("R8 engine valid", {31'b0, v}, 32'h1);
    chk("R8 engine data (write ignored)", {16'h0, d}, 32'h5A5A);
    wr16(REG_CTRL, 16'h0000);
    rd16(11'd50, d); chk("R8 data intact", {16'h0, d}, 32'h5A5A);
  endtask

  task automatic t_engine();
    logic [15:0] d; logic v;
    eng_read(10'd5, v, d);
    chk("R9 no rvalid without emu", {31'b0, v}, 32'h0);
    wr16(REG_CTRL, 16'h0004);
    eng_read(10'd5, v, d);
    chk("R9 rvalid one cycle later", {31'b0, v}, 32'h1);
    chk("R9 engine data", {16'h0, d}, 32'h1234);
    @(posedge clk); @(negedge clk);
    chk("R9 rvalid drops", {31'b0, eng_rvalid}, 32'h0);
  endtask

  task automatic t_conflict();
    int lat;
    @(negedge clk);
    host_valid = 1'b1; host_wr = 1'b0; host_word = 1'b0; host_addr = 11'd5;
    eng_req = 1'b1; eng_addr = 10'd40;
    #1;
    chk("R10 wait raised", {31'b0, host_wait}, 32'h1);
    @(posedge clk);
    @(negedge clk);
    eng_req = 1'b0;
    chk("R10 engine served", {31'b0, eng_rvalid}, 32'h1);
    chk("R10 engine data", {16'h0, eng_rdata}, 32'hBEEF);
    chk("R10 host not done yet", {31'b0, host_done}, 32'h0);
    lat = 1;
    while (!host_done && lat < 20) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    host_valid = 1'b0;
    chk("R10 host completes after stall", lat, 2);
    chk("R10 host data", {16'h0, host_rdata}, 32'h1234);
    wr16(REG_CTRL, 16'h0000);
  endtask

  task automatic t_freeze();
    logic [15:0] d; logic v;
    freeze = 1'b1;
    wr16(11'd60, 16'hC0DE);
    rd16(11'd60, d); chk("R11 host works in freeze", {16'h0, d}, 32'hC0DE);
    wr16(REG_CTRL, 16'h0004);
    eng_read(10'd60, v, d);
    chk("R11 engine works in freeze", {15'b0, v, d}, {15'b0, 1'b1, 16'hC0DE});
    wr16(REG_CTRL, 16'h0000);
    freeze = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_half();
    t_word();
    t_reset_first();
    t_reset_second();
    t_ctrl();
    t_stop();
    t_off();
    t_engine();
    t_conflict();
    t_freeze();
    summary();
  end
endmodule